// File: doc/BRIEF.md
# Serial Link Frame Encoder

This block turns a parallel user word into one line frame per clock for an external serializer. Each frame is a data field of 20 or 16 bits, chosen by a static mode input, topped by a 4-bit coding field. Every cycle the encoder decides whether to emit a data frame, a control frame or a fill frame. Fill frames keep the far receiver able to acquire and hold lock while no payload is sent.

Fill comes in two stages. Until the link reports lock, the encoder sends a square wave: the lower half of the active field is high and the upper half is low. Once locked, it sends one of two variants. Both bits at the centre edge are forced low or both forced high, which moves the falling edge by one position. The variant is picked to pull the running line disparity back towards zero. Data and control frames are complemented as a whole whenever that helps DC balance. The complemented coding field tells the receiver to undo it.

Top module: `frame_encoder`

## Requirements
- R1: While reset is asserted the frame output holds coding field 4'b1010 over an all-zero data field, and the running disparity restarts from zero.
- R2: Inputs are sampled at a rising clock edge and the frame they select appears on `frame_out` after that same edge (one cycle of latency).
- R3: While `link_locked` is low the encoder sends the startup fill: coding 4'b1010, data bits below W/2 high and bits W/2 to W-1 low (W = 20 or 16). This gives a falling edge between bits 9 and 10 in wide mode and between bits 7 and 8 in narrow mode.
- R4: With the link locked, a fill frame is sent when `force_fill` is high, when `send_enable` is low, or when neither `data_avail` nor `ctrl_avail` is high. Fill frames are never complemented.
- R5: A fill frame after lock sets data bits W/2-1 and W/2 both to 1 when the running disparity is negative, and both to 0 otherwise. All other bits follow the startup pattern.
- R6: A payload frame carries `word_in` in the active data bits. Its coding field is 4'b1101 for control and 4'b1100 for data, and control wins when both are available.
- R7: A payload frame whose own disparity and the running disparity are both non-zero and of the same sign is sent bitwise complemented over its active bits (coding then reads 4'b0010 or 4'b0011).
- R8: The running disparity is the sum, over sent frames, of ones minus zeros across the 4 coding bits and the W active data bits. Its magnitude never exceeds W+4.
- R9: In narrow mode (`wide_mode` low) data bits 19:16 of the frame are always 0, and bits 19:16 of `word_in` have no effect.
- R10: Coding field bits 2 and 1 always differ, so every frame has its master transition at the same place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 20-bit data field, 0: 16-bit data field (static) |
| word_in | input | 20 | User payload word |
| data_avail | input | 1 | A data word is offered |
| ctrl_avail | input | 1 | A control word is offered |
| send_enable | input | 1 | Payload transmission allowed |
| force_fill | input | 1 | Error condition: send fill |
| link_locked | input | 1 | Receiver reports frequency lock |
| frame_out | output | 24 | Registered frame: coding in [23:20], data in [19:0] |

## Verification
The bench builds the encoder with its defaults: a 20-bit wide field and a 16-bit narrow field. It runs both modes in turn, with a reset between them, so the fill edge is tested at both centre positions (9/10 and 7/8). Long runs of all-ones and all-zeros payload drive the running disparity to its extremes, which exercises complementing in both directions. Random traffic then mixes fill variants with payload and checks that the tally stays within W+4.

// File: rtl/frame_enc_pkg.sv
package frame_enc_pkg;
    localparam int CODE_W = 4;

    // Bits 2 and 1 always differ: the master transition is fixed.
    localparam logic [CODE_W-1:0] CODE_DATA = 4'b1100;
    localparam logic [CODE_W-1:0] CODE_CTRL = 4'b1101;
    localparam logic [CODE_W-1:0] CODE_FILL = 4'b1010;

    typedef enum logic [1:0] {
        KIND_FILL,
        KIND_DATA,
        KIND_CTRL
    } frame_kind_e;
endpackage

// File: rtl/frame_fill_gen.sv
module frame_fill_gen #(
    parameter int MAX_W    = 20,
    parameter int NARROW_W = 16
) (
    input  logic             wide,
    input  logic             locked,
    input  logic             pick_high,
    output logic [MAX_W-1:0] field
);
    localparam int HALF_WIDE   = MAX_W / 2;
    localparam int HALF_NARROW = NARROW_W / 2;

    logic [MAX_W-1:0] sq_wide;
    logic [MAX_W-1:0] sq_narrow;

    for (genvar i = 0; i < MAX_W; i++) begin : g_bit
        assign sq_wide[i]   = (i < HALF_WIDE);
        assign sq_narrow[i] = (i < HALF_NARROW);
    end

    always_comb begin
        field = wide ? sq_wide : sq_narrow;
        if (locked) begin
            if (wide) begin
                field[HALF_WIDE-1] = pick_high;
                field[HALF_WIDE]   = pick_high;
            end else begin
                field[HALF_NARROW-1] = pick_high;
                field[HALF_NARROW]   = pick_high;
            end
        end
    end
endmodule

// File: rtl/frame_disparity.sv
module frame_disparity #(
    parameter int FRAME_W = 24,
    parameter int RD_W    = 8
) (
    input  logic [FRAME_W-1:0]     bits,
    input  logic [FRAME_W-1:0]     mask,
    output logic signed [RD_W-1:0] disp
);
    int ones;
    int total;

    always_comb begin
        ones  = 0;
        total = 0;
        for (int i = 0; i < FRAME_W; i++) begin
            if (mask[i]) begin
                total = total + 1;
                if (bits[i]) ones = ones + 1;
            end
        end
        disp = RD_W'(2 * ones - total);
    end
endmodule

// File: rtl/frame_encoder.sv
module frame_encoder
    import frame_enc_pkg::*;
#(
    parameter int MAX_W    = 20,
    parameter int NARROW_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wide_mode,
    input  logic [MAX_W-1:0]          word_in,
    input  logic                      data_avail,
    input  logic                      ctrl_avail,
    input  logic                      send_enable,
    input  logic                      force_fill,
    input  logic                      link_locked,
    output logic [MAX_W+CODE_W-1:0]   frame_out
);
    localparam int FRAME_W = MAX_W + CODE_W;
    localparam int RD_W    = $clog2(FRAME_W) + 3;
    localparam logic [MAX_W-1:0] WIDE_MASK   = {MAX_W{1'b1}};
    localparam logic [MAX_W-1:0] NARROW_MASK = {{(MAX_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [FRAME_W-1:0]     frame;
        logic signed [RD_W-1:0] rd;
    } enc_state_t;

    enc_state_t state_d, state_q;

    logic signed [RD_W-1:0] rd_now;
    logic signed [RD_W-1:0] disp_raw;
    logic [MAX_W-1:0]       fill_field;
    logic [MAX_W-1:0]       data_mask;
    logic [FRAME_W-1:0]     full_mask;
    logic [FRAME_W-1:0]     raw_frame;
    logic [CODE_W-1:0]      code_sel;
    frame_kind_e            kind;
    logic                   invert;

    assign rd_now = state_q.rd;

    frame_fill_gen #(.MAX_W(MAX_W), .NARROW_W(NARROW_W)) i_fill (
        .wide      (wide_mode),
        .locked    (link_locked),
        .pick_high (rd_now[RD_W-1]),
        .field     (fill_field)
    );

    frame_disparity #(.FRAME_W(FRAME_W), .RD_W(RD_W)) i_disp (
        .bits (raw_frame),
        .mask (full_mask),
        .disp (disp_raw)
    );

    always_comb begin
        data_mask = wide_mode ? WIDE_MASK : NARROW_MASK;
        full_mask = {{CODE_W{1'b1}}, data_mask};

        if (!link_locked || force_fill || !send_enable)
            kind = KIND_FILL;
        else if (ctrl_avail)
            kind = KIND_CTRL;
        else if (data_avail)
            kind = KIND_DATA;
        else
            kind = KIND_FILL;

        unique case (kind)
            KIND_CTRL: code_sel = CODE_CTRL;
            KIND_DATA: code_sel = CODE_DATA;
            default:   code_sel = CODE_FILL;
        endcase

        if (kind == KIND_FILL)
            raw_frame = {code_sel, fill_field};
        else
            raw_frame = {code_sel, word_in & data_mask};

        invert = (kind != KIND_FILL) && (disp_raw != '0) && (rd_now != '0)
                 && (disp_raw[RD_W-1] == rd_now[RD_W-1]);

        state_d = state_q;
        if (invert) begin
            state_d.frame = ~raw_frame & full_mask;
            state_d.rd    = rd_now - disp_raw;
        end else begin
            state_d.frame = raw_frame;
            state_d.rd    = rd_now + disp_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.frame <= {CODE_FILL, {MAX_W{1'b0}}};
            state_q.rd    <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign frame_out = state_q.frame;

    // R10: master transition always present in the coding field
    p_code_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_out[MAX_W+2] != frame_out[MAX_W+1]);

    // R3: no payload before lock
    p_unlocked_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !link_locked |=> frame_out[FRAME_W-1 -: CODE_W] == CODE_FILL);

    // R4: an error condition forces an uncomplemented fill
    p_forced_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_fill |=> frame_out[FRAME_W-1 -: CODE_W] == CODE_FILL);

    // R6: control wins over data
    p_ctrl_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_locked && send_enable && !force_fill && ctrl_avail) |=>
        (frame_out[FRAME_W-1 -: CODE_W] == CODE_CTRL ||
         frame_out[FRAME_W-1 -: CODE_W] == ~CODE_CTRL));

    // R8: running disparity stays bounded
    p_rd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now <= $signed(RD_W'(FRAME_W))) && (rd_now >= -$signed(RD_W'(FRAME_W))));

    // R9: unused upper data bits stay low in narrow mode
    p_narrow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |=> frame_out[MAX_W-1:NARROW_W] == '0);
endmodule

// File: tb/test_frame_encoder.sv
module test_frame_encoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic [19:0] word_in = '0;
    logic        data_avail = 1'b0;
    logic        ctrl_avail = 1'b0;
    logic        send_enable = 1'b0;
    logic        force_fill = 1'b0;
    logic        link_locked = 1'b0;
    logic [23:0] frame_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_rd   = 0;
    int obs_rd = 0;
    logic [23:0] exp_frame;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_encoder i_frame_encoder (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .word_in(word_in),
        .data_avail(data_avail), .ctrl_avail(ctrl_avail), .send_enable(send_enable),
        .force_fill(force_fill), .link_locked(link_locked), .frame_out(frame_out)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference: builds the expected frame and advances the tally.
    task automatic model(input string forced_tag);
        int w, half, ones, d;
        bit fill, inv;
        logic [23:0] f;
        w = wide_mode ? 20 : 16;
        half = w / 2;
        fill = !link_locked || force_fill || !send_enable || (!data_avail && !ctrl_avail);
        f = '0;
        if (fill) begin
            f[23:20] = 4'b1010;
            for (int i = 0; i < half; i++) f[i] = 1'b1;
            if (link_locked) begin
                f[half-1] = (m_rd < 0);
                f[half]   = (m_rd < 0);
            end
        end else begin
            f[23:20] = ctrl_avail ? 4'b1101 : 4'b1100;
            for (int i = 0; i < w; i++) f[i] = word_in[i];
        end
        ones = 0;
        for (int i = 0; i < 24; i++) if ((i < w || i >= 20) && f[i]) ones++;
        d = 2 * ones - (w + 4);
        inv = !fill && d != 0 && m_rd != 0 && ((d > 0) == (m_rd > 0));
        if (inv) begin
            for (int i = 0; i < 24; i++) if (i < w || i >= 20) f[i] = ~f[i];
            m_rd = m_rd - d;
        end else begin
            m_rd = m_rd + d;
        end
        exp_frame = f;
        if (forced_tag != "")      exp_tag = forced_tag;
        else if (!wide_mode)       exp_tag = "R9";
        else if (fill && !link_locked) exp_tag = "R3";
        else if (fill && (force_fill || !send_enable)) exp_tag = "R4";
        else if (fill)             exp_tag = "R5";
        else if (inv)              exp_tag = "R7";
        else                       exp_tag = "R6";
    endtask

    task automatic observe();
        int w, ones;
        w = wide_mode ? 20 : 16;
        check(frame_out === exp_frame, exp_tag, frame_out, exp_frame);
        check(frame_out[22] != frame_out[21], "R10", frame_out, exp_frame);
        ones = 0;
        for (int i = 0; i < 24; i++) if ((i < w || i >= 20) && frame_out[i]) ones++;
        obs_rd = obs_rd + 2 * ones - (w + 4);
        check(obs_rd <= w + 4 && obs_rd >= -(w + 4), "R8", 24'(obs_rd), 24'(w + 4));
    endtask

    task automatic cycle(input logic [19:0] wd, input logic dv, input logic cv,
                         input logic en, input logic ff, input logic lk, input string tag);
        word_in = wd; data_avail = dv; ctrl_avail = cv;
        send_enable = en; force_fill = ff; link_locked = lk;
        model(tag);
        @(negedge clk);
        observe();
    endtask

    task automatic do_reset(input logic wide);
        rst_n = 1'b0;
        wide_mode = wide;
        word_in = 20'hFFFFF; data_avail = 1'b1; link_locked = 1'b1; send_enable = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset frame is fill code over zero data
        check(frame_out === 24'hA00000, "R1", frame_out, 24'hA00000);
        m_rd = 0;
        obs_rd = 0;
        rst_n = 1'b1;
    endtask

    task automatic phase(input logic wide);
        do_reset(wide);
        // R2: the first frame after reset follows the inputs of the first edge
        cycle(20'h12345, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
        repeat (4) cycle(20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "");
        // lock and drive disparity positive with all-ones payload (R7)
        repeat (6) cycle(20'hFFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "");
        // then negative with all-zero control words (R7, R6)
        repeat (6) cycle(20'h00000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "");
        // idle fills pick variants from the tally (R5)
        repeat (4) cycle(20'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "");
        cycle(20'hFFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "");
        repeat (3) cycle(20'hFFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "");
        // error and disable force fill (R4)
        cycle(20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "");
        cycle(20'hFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "");
        // lock lost: back to startup fill (R3)
        repeat (2) cycle(20'hFFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "");
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(20'($urandom), r[0], r[1], r[2] | r[3], r[4] & r[5] & r[6],
                  r[7] | r[8] | r[9], "");
        end
    endtask

    initial begin
        @(negedge clk);
        phase(1'b1);
        phase(1'b0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule